// File: doc/BRIEF.md
# Low Power Mode Controller

This block sequences the two sleep modes of a small microcontroller core. Software raises a one-cycle request to enter a light sleep, in which the CPU clock is gated and peripherals keep running, or a deep sleep, in which the CPU clock, the peripheral clocks and the oscillator enable are all dropped. While either mode is active, the block drives overrides for the address-latch strobe, the program-store strobe and the ports. These depend on the mode and on whether code comes from internal or external program memory.

Light sleep ends when any enabled interrupt becomes pending. Deep sleep ignores ordinary interrupts. It ends only through a hardware reset or through one of the external interrupt pins, and that pin must be enabled and configured as level-sensitive. A low level on such a pin turns the oscillator enable back on. The CPU clock returns only after a programmable settling interval has elapsed and every qualifying pin has gone high again. On each return to normal execution, the block emits a one-cycle resume strobe, and the core continues at the instruction after the one that requested sleep.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the block is in normal run: cpu_clk_en, per_clk_en and osc_en are 1, ctl_hold, p0_float, p2_addr and resume are 0.
- R2: A req_idle pulse in run makes cpu_clk_en 0 on the next cycle while per_clk_en and osc_en stay 1.
- R3: In light sleep, irq_pending=1 restores cpu_clk_en on the next cycle, together with a resume pulse that lasts exactly one cycle.
- R4: A req_pdown pulse in run drops cpu_clk_en, per_clk_en and osc_en on the next cycle; when req_idle and req_pdown arrive together, deep sleep is entered.
- R5: In deep sleep, irq_pending, a low on a disabled pin and a low on an edge-configured pin (xint_level bit 0) leave osc_en at 0.
- R6: In deep sleep, a low on a pin with xint_en=1 and xint_level=1 sets osc_en to 1 within three cycles, and cpu_clk_en stays 0 as long as the pin stays low.
- R7: After a deep-sleep wake, cpu_clk_en returns only once every qualifying pin is high, and no earlier than settle_cycles+1 cycles after osc_en rose; it returns with a one-cycle resume pulse.
- R8: ctl_hold is 1 in both sleep modes and 0 in run; ctl_level (the value forced on both strobes) is 1 in light sleep and 0 in deep sleep, including the settling interval.
- R9: With code_ext=1, p0_float is 1 in both sleep modes, and p2_addr (port 2 keeps the address) is 1 in light sleep and 0 in deep sleep; with code_ext=0 both are 0.
- R10: Sleep requests that arrive while not in run have no effect.
- R11: Asserting rst_n low from any mode returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| req_idle | input | 1 | One-cycle light-sleep request |
| req_pdown | input | 1 | One-cycle deep-sleep request |
| irq_pending | input | 1 | OR of the enabled pending interrupt flags |
| xint_n | input | NPIN | External interrupt pins, active low, asynchronous |
| xint_en | input | NPIN | Per-pin interrupt enable |
| xint_level | input | NPIN | Per-pin trigger: 1 level, 0 edge |
| code_ext | input | 1 | 1 when code executes from external memory |
| settle_cycles | input | CNT_W | Settling interval after oscillator restart, in clocks |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ctl_hold | output | 1 | Override the two memory strobes |
| ctl_level | output | 1 | Value forced on the strobes while held |
| p0_float | output | 1 | Port 0 driven to high impedance |
| p2_addr | output | 1 | Port 2 keeps the high address instead of latch data |
| resume | output | 1 | One-cycle strobe on return to run |

## Verification
The bench targets deep sleep against interrupts that must not wake it: a design that woke on irq_pending or on an edge-configured pin would raise osc_en. It releases the wake pin both before and after the settling interval, which catches a design that resumes on the rising pin alone or on the count alone. It pairs both requests in one cycle to catch a wrong priority, and it switches the code source under random mode sequences to catch port 2 keeping the address in deep sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PDOWN = 2'd2,
    ST_WARM  = 2'd3
  } lpm_state_e;

  typedef struct packed {
    logic hold;
    logic level;
    logic p0_float;
    logic p2_addr;
  } pin_ovr_t;
endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
  parameter int NPIN = 2,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_n,
  input  logic [NPIN-1:0] en,
  input  logic [NPIN-1:0] lvl_cfg,
  output logic            wake_low
);
  logic [NPIN-1:0] synced;
  logic [NPIN-1:0] qual;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [SYNC-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC-2:0], pin_n[g]};
    end
    assign synced[g] = chain[SYNC-1];
    assign qual[g]   = en[g] & lvl_cfg[g] & ~synced[g];
  end

  assign wake_low = |qual;
endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] init,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= init;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_TMR_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(cnt)); // R7
  AST_TMR_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(init))); // R7
endmodule

// File: rtl/lpm_pin_override.sv
module lpm_pin_override
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       code_ext,
  output pin_ovr_t   ovr
);
  always_comb begin
    ovr = '0;
    unique case (state)
      ST_RUN: ovr = '0;
      ST_IDLE: begin
        ovr.hold     = 1'b1;
        ovr.level    = 1'b1;
        ovr.p0_float = code_ext;
        ovr.p2_addr  = code_ext;
      end
      ST_PDOWN, ST_WARM: begin
        ovr.hold     = 1'b1;
        ovr.level    = 1'b0;
        ovr.p0_float = code_ext;
        ovr.p2_addr  = 1'b0;
      end
      default: ovr = '0;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NPIN  = 2,
  parameter int SYNC  = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_idle,
  input  logic             req_pdown,
  input  logic             irq_pending,
  input  logic [NPIN-1:0]  xint_n,
  input  logic [NPIN-1:0]  xint_en,
  input  logic [NPIN-1:0]  xint_level,
  input  logic             code_ext,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             ctl_hold,
  output logic             ctl_level,
  output logic             p0_float,
  output logic             p2_addr,
  output logic             resume
);
  lpm_state_e st, st_nxt;
  logic       wake_low;
  logic       settle_done;
  logic       tmr_load, tmr_run;
  logic       resume_q;
  pin_ovr_t   ovr;

  lpm_wake_detect #(.NPIN(NPIN), .SYNC(SYNC)) u_wake (
    .clk(clk), .rst_n(rst_n), .pin_n(xint_n), .en(xint_en),
    .lvl_cfg(xint_level), .wake_low(wake_low)
  );

  assign tmr_load = (st == ST_PDOWN) && wake_low;
  assign tmr_run  = (st == ST_WARM);

  lpm_settle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run),
    .init(settle_cycles), .done(settle_done)
  );

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_RUN: begin
        if (req_pdown)     st_nxt = ST_PDOWN;
        else if (req_idle) st_nxt = ST_IDLE;
      end
      ST_IDLE:  if (irq_pending) st_nxt = ST_RUN;
      ST_PDOWN: if (wake_low)    st_nxt = ST_WARM;
      ST_WARM:  if (settle_done && !wake_low) st_nxt = ST_RUN;
      default:  st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      resume_q <= 1'b0;
    end else begin
      st       <= st_nxt;
      resume_q <= (st != ST_RUN) && (st_nxt == ST_RUN);
    end
  end

  lpm_pin_override u_pins (.state(st), .code_ext(code_ext), .ovr(ovr));

  assign cpu_clk_en = (st == ST_RUN);
  assign per_clk_en = (st == ST_RUN) || (st == ST_IDLE);
  assign osc_en     = (st != ST_PDOWN);
  assign ctl_hold   = ovr.hold;
  assign ctl_level  = ovr.level;
  assign p0_float   = ovr.p0_float;
  assign p2_addr    = ovr.p2_addr;
  assign resume     = resume_q;

  AST_PD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && req_pdown) |=> (st == ST_PDOWN)); // R4
  AST_PD_STAYS_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PDOWN && !wake_low) |=> !osc_en); // R5
  AST_WARM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WARM && (wake_low || !settle_done)) |=> !cpu_clk_en); // R7
  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R3
  AST_RESUME_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> cpu_clk_en); // R7
  AST_HOLD_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hold |-> !cpu_clk_en); // R8
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PDOWN && !wake_low && req_idle) |=> (st == ST_PDOWN)); // R10
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb_top;
  localparam int CNT_W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_idle = 0, req_pdown = 0, irq_pending = 0, code_ext = 0;
  logic [1:0] xint_n = 2'b11, xint_en = 2'b00, xint_level = 2'b00;
  logic [CNT_W-1:0] settle_cycles = '0;
  logic cpu_clk_en, per_clk_en, osc_en, ctl_hold, ctl_level, p0_float, p2_addr, resume;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lpm_ctrl #(.NPIN(2), .SYNC(2), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_pdown(req_pdown),
    .irq_pending(irq_pending), .xint_n(xint_n), .xint_en(xint_en),
    .xint_level(xint_level), .code_ext(code_ext), .settle_cycles(settle_cycles),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .ctl_hold(ctl_hold), .ctl_level(ctl_level), .p0_float(p0_float),
    .p2_addr(p2_addr), .resume(resume)
  );

  // mode: 0 run, 1 light sleep, 2 deep sleep
  function automatic logic [7:0] exp_outs(input int mode, input logic ext);
    logic cpu, per, osc, hold, lvl, p0, p2;
    cpu = (mode == 0); per = (mode != 2); osc = (mode != 2);
    hold = (mode != 0); lvl = (mode == 1);
    p0 = (mode != 0) && ext; p2 = (mode == 1) && ext;
    return {1'b0, cpu, per, osc, hold, lvl, p0, p2};
  endfunction

  function automatic logic [7:0] act_outs();
    return {1'b0, cpu_clk_en, per_clk_en, osc_en, ctl_hold, ctl_level, p0_float, p2_addr};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic pulse_req(input logic i, input logic p);
    req_idle = i; req_pdown = p;
    step(1);
    req_idle = 0; req_pdown = 0;
  endtask

  // waits for cpu_clk_en, checks one-cycle resume; returns cycles waited
  task automatic wait_resume(input string req, output int waited);
    waited = 0;
    while (!cpu_clk_en && waited < 5000) begin step(1); waited++; end
    chk(req, {31'd0, cpu_clk_en}, 32'd1);
    chk(req, {31'd0, resume}, 32'd1);
    step(1);
    chk(req, {31'd0, resume}, 32'd0);
  endtask

  task automatic deep_wake(input int settle, input int low_len, input string req);
    int warm;
    int w;
    settle_cycles = CNT_W'(settle);
    xint_en = 2'b01; xint_level = 2'b01;
    xint_n[0] = 1'b0;
    warm = 0;
    for (int k = 0; k < low_len; k++) begin
      step(1);
      if (osc_en && !cpu_clk_en) warm++;
      if (cpu_clk_en) chk({req, " cpu on while pin low"}, 32'd1, 32'd0);
      if (k >= 3) chk({req, " osc restarted"}, {31'd0, osc_en}, 32'd1);
    end
    xint_n[0] = 1'b1;
    while (!cpu_clk_en && warm < 5000) begin step(1); if (!cpu_clk_en) warm++; end
    checks++;
    if (warm < settle + 1) begin
      fails++;
      $display("FAIL %s: actual %0d warm cycles expected >= %0d", req, warm, settle + 1);
    end
    chk({req, " resume"}, {31'd0, resume}, 32'd1);
    step(1);
    chk({req, " resume width"}, {31'd0, resume}, 32'd0);
    w = 0;
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int w;
    void'($urandom(32'd12345));
    step(3);
    chk("R1 reset outputs", act_outs(), exp_outs(0, 1'b0));
    chk("R1 reset resume", {31'd0, resume}, 32'd0);
    rst_n = 1'b1;
    step(2);
    chk("R1 after release", act_outs(), exp_outs(0, 1'b0));

    // R2/R8/R9 light sleep, external code
    code_ext = 1;
    pulse_req(1, 0);
    chk("R2 idle entry", act_outs(), exp_outs(1, 1'b1));
    step(5);
    chk("R8 R9 idle hold ext", act_outs(), exp_outs(1, 1'b1));
    pulse_req(0, 1);
    chk("R10 request in idle ignored", act_outs(), exp_outs(1, 1'b1));
    irq_pending = 1;
    step(1);
    irq_pending = 0;
    chk("R3 idle exit", {31'd0, cpu_clk_en}, 32'd1);
    chk("R3 resume", {31'd0, resume}, 32'd1);
    step(1);
    chk("R3 resume one cycle", {31'd0, resume}, 32'd0);

    // R4 both requests together
    pulse_req(1, 1);
    chk("R4 deep priority", act_outs(), exp_outs(2, 1'b1));
    // R5 no wake from irq, disabled pin, edge pin
    irq_pending = 1;
    xint_en = 2'b10; xint_level = 2'b01; xint_n = 2'b00;
    step(6);
    chk("R5 irq/disabled pin ignored", {31'd0, osc_en}, 32'd0);
    xint_en = 2'b01; xint_level = 2'b00;
    step(6);
    chk("R5 edge pin ignored", {31'd0, osc_en}, 32'd0);
    irq_pending = 0; xint_n = 2'b11;
    pulse_req(1, 0);
    chk("R10 request in deep ignored", act_outs(), exp_outs(2, 1'b1));
    step(2);

    // R6/R7 early release, long settle
    deep_wake(20, 4, "R6 R7 early release");
    // R11 reset from deep sleep
    code_ext = 0;
    pulse_req(0, 1);
    chk("R9 deep internal code", act_outs(), exp_outs(2, 1'b0));
    rst_n = 0;
    step(1);
    chk("R11 reset from deep", act_outs(), exp_outs(0, 1'b0));
    rst_n = 1;
    step(1);
    // R7 long low, short settle; check R8 level low during warm
    pulse_req(0, 1);
    settle_cycles = 2;
    xint_en = 2'b01; xint_level = 2'b01; xint_n[0] = 0;
    step(6);
    chk("R8 warm strobes low", {30'd0, ctl_hold, ctl_level}, 32'd2);
    xint_n[0] = 1;
    wait_resume("R7 long low resume", w);
    // R11 reset from light sleep
    pulse_req(1, 0);
    rst_n = 0; step(1);
    chk("R11 reset from idle", act_outs(), exp_outs(0, 1'b0));
    rst_n = 1; step(1);

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic deep;
      code_ext = 1'($urandom_range(0, 1));
      deep = 1'($urandom_range(0, 1));
      pulse_req(~deep, deep);
      step($urandom_range(0, 5));
      chk(deep ? "R4 R8 R9 random deep" : "R2 R8 R9 random idle",
          act_outs(), exp_outs(deep ? 2 : 1, code_ext));
      if (deep) deep_wake($urandom_range(0, 15), $urandom_range(1, 30), "R7 random wake");
      else begin
        irq_pending = 1; step(1); irq_pending = 0;
        chk("R3 random idle exit", {30'd0, cpu_clk_en, resume}, 32'd3);
        step(1);
      end
      step($urandom_range(1, 3));
      chk("R1 back in run", act_outs(), exp_outs(0, code_ext));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule